// File: doc/BRIEF.md
# Halt and Auto-Wakeup Power Controller

This block steps a small microcontroller into a low-power halt and back out again. A halt request from the CPU either stops the chip or, when the watchdog is running and the option to keep it running in halt is clear, turns into a reset request. The auto-wakeup enable picks the halt variant. In the auto-wakeup variant the low-speed wakeup RC oscillator keeps running so that its timer interrupt can end the halt. In the plain variant every oscillator this block controls is stopped.

A wake event is either a qualified interrupt or a reset request arriving during halt. It restarts the main oscillator and holds the CPU for a stabilization delay of 256 or 4096 cycles. When the delay ends, the wakeup oscillator stops and the CPU and peripheral clocks run again. The CPU is then sent either a reset request or an interrupt-service request, together with the interrupt-mask bits for that service. Peripherals clocked from an external source are outside the gated clock set.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After reset the main oscillator, CPU clock and peripheral clock enables are 1, the wakeup oscillator enable is 0, the mask bits `imask_o` are 2'b11, and both request outputs are 0.
- R2: A halt request with `wdg_en_i`=1 and `wdg_halt_ok_i`=0 gives `rst_req_o`=1 for exactly the next cycle. The clocks keep running and no halt is entered.
- R3: Any other halt request stops the main oscillator, the CPU clock and the peripheral clock from the next cycle. The wakeup oscillator enable follows `awu_en_i` as sampled at that halt request.
- R4: While the CPU clock is off (halt and stabilization), `imask_o` is 2'b10.
- R5: Only interrupt sources in the wake mask end a halt; by default these are source 0 (auto-wakeup timer) and source 1 (external). Source 0 counts only in the auto-wakeup variant. Every other source is ignored. `rst_wake_i` ends either variant.
- R6: From the cycle after a wake event is sampled, the main oscillator is on and the CPU and peripheral clocks are off. This lasts exactly 256 cycles when `long_dly_i`=0, or 4096 when it is 1, with `long_dly_i` sampled with the wake event. The wakeup oscillator keeps its halt state during this time.
- R7: When the delay ends, the wakeup oscillator enable goes to 0 and the CPU and peripheral clocks come back on, in the same cycle.
- R8: In the first running cycle after the delay, one pulse is given. It is `rst_req_o` if a reset wake was latched. Otherwise it is `isr_req_o`, with `isr_id_o` set to the lowest-numbered latched wake source. The two requests are never high together.
- R9: On that interrupt entry `imask_o` takes the source's 2-bit priority from `irq_prio_i[2*id+1:2*id]`. A pulse on `isr_done_i` then restores the value held before entry (2'b10).
- R10: A wake event during stabilization is latched and does not restart the delay. A latched reset wake takes precedence over latched interrupts at exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req_i | input | 1 | CPU executes a halt (one-cycle pulse) |
| awu_en_i | input | 1 | Selects the auto-wakeup halt variant |
| wdg_en_i | input | 1 | Watchdog running |
| wdg_halt_ok_i | input | 1 | Option: 1 lets halt proceed with watchdog running |
| long_dly_i | input | 1 | Stabilization length: 0 = 256, 1 = 4096 cycles |
| irq_i | input | NUM_SRC | Interrupt source events |
| irq_prio_i | input | 2*NUM_SRC | Per-source software priority, 2 bits each |
| rst_wake_i | input | 1 | Reset request arriving during halt |
| isr_done_i | input | 1 | Interrupt service finished (restore mask) |
| main_osc_en_o | output | 1 | Main oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Gated peripheral clock enable |
| awu_osc_en_o | output | 1 | Wakeup RC oscillator enable |
| rst_req_o | output | 1 | Reset request pulse |
| isr_req_o | output | 1 | Interrupt-service request pulse |
| isr_id_o | output | IDW | Source to service |
| imask_o | output | 2 | Interrupt-mask bits |

## Verification
The bench measures the stabilization window cycle by cycle for both lengths. A counter that was off by one, or that restarted on a second wake, would give a window length other than 256 or 4096. It pulses non-qualified sources, and the auto-wakeup source in the plain variant. A design that honoured them would leave halt early. It sends a second interrupt and a reset into the delay window. A design that dropped the latched reset would issue an interrupt-service request in its place, and one that lost the priority order would report the wrong source. It also sends a halt request under the watchdog option. A design that got this wrong would stop its clocks instead of pulsing reset.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
    localparam int CNT_W = 12;
    localparam logic [CNT_W-1:0] LIM_SHORT = 12'd255;
    localparam logic [CNT_W-1:0] LIM_LONG  = 12'd4095;
    localparam logic [1:0] IMASK_HALT = 2'b10;
    localparam logic [1:0] IMASK_RST  = 2'b11;

    typedef enum logic [1:0] {ST_RUN = 2'd0, ST_HALT = 2'd1, ST_STAB = 2'd2} pstate_e;

    typedef struct packed {
        logic main_osc;
        logic cpu_clk;
        logic periph_clk;
        logic awu_osc;
    } clk_en_t;

    function automatic logic [CNT_W-1:0] stab_limit(input logic long_sel);
        return long_sel ? LIM_LONG : LIM_SHORT;
    endfunction

    function automatic clk_en_t clk_plan(input pstate_e st, input logic awu_mode);
        clk_en_t c;
        case (st)
            ST_HALT: c = '{main_osc: 1'b0, cpu_clk: 1'b0, periph_clk: 1'b0, awu_osc: awu_mode};
            ST_STAB: c = '{main_osc: 1'b1, cpu_clk: 1'b0, periph_clk: 1'b0, awu_osc: awu_mode};
            default: c = '{main_osc: 1'b1, cpu_clk: 1'b1, periph_clk: 1'b1, awu_osc: 1'b0};
        endcase
        return c;
    endfunction
endpackage

// File: rtl/hwc_stab_timer.sv
module hwc_stab_timer #(
    parameter int CNT_W = hwc_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = run_i && (cnt_q == limit_i);
endmodule

// File: rtl/hwc_wake_sel.sv
module hwc_wake_sel #(
    parameter int                 NUM_SRC   = 4,
    parameter logic [NUM_SRC-1:0] WAKE_MASK = 4'b0011,
    parameter int                 AWU_SRC   = 0,
    localparam int                IDW       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               armed_i,
    input  logic               clear_i,
    input  logic               awu_mode_i,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic               rst_wake_i,
    output logic               hit_o,
    output logic               pend_rst_o,
    output logic [IDW-1:0]     pend_id_o
);
    logic [NUM_SRC-1:0] variant_mask;
    logic [NUM_SRC-1:0] eligible;
    logic [NUM_SRC-1:0] pend_q;
    logic               rst_pend_q;

    always_comb begin
        variant_mask = WAKE_MASK;
        if (!awu_mode_i) variant_mask[AWU_SRC] = 1'b0;
    end

    assign eligible = irq_i & variant_mask;
    assign hit_o    = armed_i && ((|eligible) || rst_wake_i);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            pend_q     <= '0;
            rst_pend_q <= 1'b0;
        end else if (armed_i) begin
            pend_q     <= pend_q | eligible;
            rst_pend_q <= rst_pend_q | rst_wake_i;
        end
    end

    always_comb begin
        pend_id_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_q[i]) pend_id_o = IDW'(i);
        end
    end

    assign pend_rst_o = rst_pend_q;
endmodule

// File: rtl/hwc_imask.sv
module hwc_imask (
    input  logic       clk,
    input  logic       rst,
    input  logic       halt_enter_i,
    input  logic       isr_enter_i,
    input  logic [1:0] isr_prio_i,
    input  logic       isr_done_i,
    output logic [1:0] imask_o
);
    import hwc_pkg::*;

    logic [1:0] cur_q;
    logic [1:0] saved_q;
    logic       in_isr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= IMASK_RST;
            saved_q  <= IMASK_RST;
            in_isr_q <= 1'b0;
        end else if (halt_enter_i) begin
            cur_q <= IMASK_HALT;
        end else if (isr_enter_i) begin
            saved_q  <= cur_q;
            cur_q    <= isr_prio_i;
            in_isr_q <= 1'b1;
        end else if (isr_done_i && in_isr_q) begin
            cur_q    <= saved_q;
            in_isr_q <= 1'b0;
        end
    end

    assign imask_o = cur_q;
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
    parameter int                 NUM_SRC   = 4,
    parameter logic [NUM_SRC-1:0] WAKE_MASK = 4'b0011,
    localparam int                IDW       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 halt_req_i,
    input  logic                 awu_en_i,
    input  logic                 wdg_en_i,
    input  logic                 wdg_halt_ok_i,
    input  logic                 long_dly_i,
    input  logic [NUM_SRC-1:0]   irq_i,
    input  logic [2*NUM_SRC-1:0] irq_prio_i,
    input  logic                 rst_wake_i,
    input  logic                 isr_done_i,
    output logic                 main_osc_en_o,
    output logic                 cpu_clk_en_o,
    output logic                 periph_clk_en_o,
    output logic                 awu_osc_en_o,
    output logic                 rst_req_o,
    output logic                 isr_req_o,
    output logic [IDW-1:0]       isr_id_o,
    output logic [1:0]           imask_o
);
    import hwc_pkg::*;

    pstate_e          st_q, st_d;
    logic             awu_mode_q;
    logic             long_q;
    logic             rst_req_q, isr_req_q;
    logic [IDW-1:0]   isr_id_q;
    clk_en_t          ce;

    logic             halt_ok, halt_to_rst, enter_halt;
    logic             wake_hit, stab_done, pend_rst;
    logic [IDW-1:0]   pend_id;
    logic             isr_enter;
    logic [1:0]       sel_prio;

    assign halt_to_rst = (st_q == ST_RUN) && halt_req_i && wdg_en_i && !wdg_halt_ok_i;
    assign halt_ok     = (st_q == ST_RUN) && halt_req_i && !halt_to_rst;
    assign enter_halt  = halt_ok;

    hwc_wake_sel #(.NUM_SRC(NUM_SRC), .WAKE_MASK(WAKE_MASK), .AWU_SRC(0)) u_wake (
        .clk        (clk),
        .rst        (rst),
        .armed_i    (st_q != ST_RUN),
        .clear_i    (stab_done),
        .awu_mode_i (awu_mode_q),
        .irq_i      (irq_i),
        .rst_wake_i (rst_wake_i),
        .hit_o      (wake_hit),
        .pend_rst_o (pend_rst),
        .pend_id_o  (pend_id)
    );

    hwc_stab_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run_i   (st_q == ST_STAB),
        .limit_i (stab_limit(long_q)),
        .done_o  (stab_done)
    );

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_RUN:  if (enter_halt) st_d = ST_HALT;
            ST_HALT: if (wake_hit)   st_d = ST_STAB;
            ST_STAB: if (stab_done)  st_d = ST_RUN;
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_RUN;
            awu_mode_q <= 1'b0;
            long_q     <= 1'b0;
            rst_req_q  <= 1'b0;
            isr_req_q  <= 1'b0;
            isr_id_q   <= '0;
        end else begin
            st_q      <= st_d;
            rst_req_q <= halt_to_rst || (stab_done && pend_rst);
            isr_req_q <= stab_done && !pend_rst;
            if (enter_halt) awu_mode_q <= awu_en_i;
            if (st_q == ST_HALT && wake_hit) long_q <= long_dly_i;
            if (stab_done && !pend_rst) isr_id_q <= pend_id;
        end
    end

    assign isr_enter = stab_done && !pend_rst;
    assign sel_prio  = irq_prio_i[{pend_id, 1'b0} +: 2];

    hwc_imask u_imask (
        .clk          (clk),
        .rst          (rst),
        .halt_enter_i (enter_halt),
        .isr_enter_i  (isr_enter),
        .isr_prio_i   (sel_prio),
        .isr_done_i   (isr_done_i),
        .imask_o      (imask_o)
    );

    assign ce              = clk_plan(st_q, awu_mode_q);
    assign main_osc_en_o   = ce.main_osc;
    assign cpu_clk_en_o    = ce.cpu_clk;
    assign periph_clk_en_o = ce.periph_clk;
    assign awu_osc_en_o    = ce.awu_osc;
    assign rst_req_o       = rst_req_q;
    assign isr_req_o       = isr_req_q;
    assign isr_id_o        = isr_id_q;
endmodule

// File: rtl/hwc_checker.sv
module hwc_checker (
    input logic       clk,
    input logic       rst,
    input logic       halt_req_i,
    input logic       wdg_en_i,
    input logic       wdg_halt_ok_i,
    input logic       main_osc_en_o,
    input logic       cpu_clk_en_o,
    input logic       periph_clk_en_o,
    input logic       awu_osc_en_o,
    input logic       rst_req_o,
    input logic       isr_req_o,
    input logic [1:0] imask_o
);
    // R2
    wdg_halt_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en_o && halt_req_i && wdg_en_i && !wdg_halt_ok_i) |=> (rst_req_o && cpu_clk_en_o));

    // R3
    osc_off_clk_off_chk: assert property (@(posedge clk) disable iff (rst)
        !main_osc_en_o |-> (!cpu_clk_en_o && !periph_clk_en_o));

    // R4
    halt_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_clk_en_o |-> (imask_o == 2'b10));

    // R7
    resume_awu_off_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en_o) |-> (!awu_osc_en_o && periph_clk_en_o));

    // R8
    one_request_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({rst_req_o, isr_req_o}) <= 1);
endmodule

bind halt_wake_ctrl hwc_checker i_hwc_checker (
    .clk             (clk),
    .rst             (rst),
    .halt_req_i      (halt_req_i),
    .wdg_en_i        (wdg_en_i),
    .wdg_halt_ok_i   (wdg_halt_ok_i),
    .main_osc_en_o   (main_osc_en_o),
    .cpu_clk_en_o    (cpu_clk_en_o),
    .periph_clk_en_o (periph_clk_en_o),
    .awu_osc_en_o    (awu_osc_en_o),
    .rst_req_o       (rst_req_o),
    .isr_req_o       (isr_req_o),
    .imask_o         (imask_o)
);

// File: tb/test_halt_wake_ctrl.sv
module test_halt_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       halt_req_i = 0, awu_en_i = 0, wdg_en_i = 0, wdg_halt_ok_i = 0, long_dly_i = 0;
    logic [3:0] irq_i = '0;
    logic [7:0] irq_prio_i = 8'b00_00_01_11;
    logic       rst_wake_i = 0, isr_done_i = 0;
    logic       main_osc_en_o, cpu_clk_en_o, periph_clk_en_o, awu_osc_en_o;
    logic       rst_req_o, isr_req_o;
    logic [1:0] isr_id_o, imask_o;
    int         total = 0, bad = 0;

    always #2 clk = ~clk;

    halt_wake_ctrl i_halt_wake_ctrl (.*);

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_halt(input logic awu);
        awu_en_i = awu;
        halt_req_i = 1;
        @(negedge clk);
        halt_req_i = 0;
    endtask

    task automatic pulse_irq(input int src);
        irq_i[src] = 1;
        @(negedge clk);
        irq_i = '0;
    endtask

    // counts delay cycles; on return sits in first running cycle
    task automatic measure(output int n);
        n = 0;
        while (main_osc_en_o && !cpu_clk_en_o && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state;
        check("R1 main", main_osc_en_o, 1);
        check("R1 cpu", cpu_clk_en_o, 1);
        check("R1 periph", periph_clk_en_o, 1);
        check("R1 awu", awu_osc_en_o, 0);
        check("R1 imask", imask_o, 2'b11);
        check("R1 reqs", {rst_req_o, isr_req_o}, 0);
    endtask

    task automatic t_wdg_reset;
        wdg_en_i = 1; wdg_halt_ok_i = 0;
        do_halt(1);
        check("R2 rst_req", rst_req_o, 1);
        check("R2 cpu kept", cpu_clk_en_o, 1);
        @(negedge clk);
        check("R2 one cycle", rst_req_o, 0);
        wdg_en_i = 0;
    endtask

    task automatic t_awu_wake;
        int n;
        long_dly_i = 0;
        do_halt(1);
        check("R3 main off", main_osc_en_o, 0);
        check("R3 cpu off", cpu_clk_en_o, 0);
        check("R3 periph off", periph_clk_en_o, 0);
        check("R3 awu on", awu_osc_en_o, 1);
        check("R4 imask halt", imask_o, 2'b10);
        pulse_irq(2);
        repeat (3) @(negedge clk);
        check("R5 src2 ignored", main_osc_en_o, 0);
        pulse_irq(1);
        check("R6 awu kept", awu_osc_en_o, 1);
        check("R4 imask stab", imask_o, 2'b10);
        measure(n);
        check("R6 short length", n, 256);
        check("R7 awu off", awu_osc_en_o, 0);
        check("R7 periph on", periph_clk_en_o, 1);
        check("R8 isr_req", isr_req_o, 1);
        check("R8 isr_id", isr_id_o, 1);
        check("R8 no rst", rst_req_o, 0);
        check("R9 prio", imask_o, 2'b01);
        @(negedge clk);
        check("R8 pulse", isr_req_o, 0);
        isr_done_i = 1;
        @(negedge clk);
        isr_done_i = 0;
        check("R9 restore", imask_o, 2'b10);
    endtask

    task automatic t_plain_long;
        int n;
        wdg_en_i = 1; wdg_halt_ok_i = 1;
        do_halt(0);
        check("R3 plain halt", cpu_clk_en_o, 0);
        check("R3 plain awu", awu_osc_en_o, 0);
        pulse_irq(0);
        repeat (3) @(negedge clk);
        check("R5 src0 ignored plain", main_osc_en_o, 0);
        long_dly_i = 1;
        pulse_irq(1);
        long_dly_i = 0;
        measure(n);
        check("R6 long length", n, 4096);
        check("R8 isr_id", isr_id_o, 1);
        wdg_en_i = 0;
    endtask

    task automatic t_late_irq;
        int n, m;
        do_halt(1);
        pulse_irq(1);
        repeat (99) @(negedge clk);
        pulse_irq(0);
        measure(m);
        n = m + 100;
        check("R10 no restart", n, 256);
        check("R10 lowest id", isr_id_o, 0);
        check("R9 prio src0", imask_o, 2'b11);
        isr_done_i = 1;
        @(negedge clk);
        isr_done_i = 0;
    endtask

    task automatic t_reset_exit;
        int n;
        do_halt(0);
        rst_wake_i = 1;
        @(negedge clk);
        rst_wake_i = 0;
        measure(n);
        check("R5 rst wakes plain", n, 256);
        check("R8 rst_req", rst_req_o, 1);
        check("R8 no isr", isr_req_o, 0);
        @(negedge clk);
        do_halt(1);
        pulse_irq(0);
        repeat (20) @(negedge clk);
        rst_wake_i = 1;
        @(negedge clk);
        rst_wake_i = 0;
        measure(n);
        check("R10 rst priority", rst_req_o, 1);
        check("R10 no isr", isr_req_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset_state();
        t_wdg_reset();
        t_awu_wake();
        t_plain_long();
        t_late_irq();
        t_reset_exit();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule